// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the slave side of a 256-byte serial memory on a two-wire bus. Its SCL and SDA inputs are already synchronised to the system clock. It finds start and stop conditions and receives a device select byte, a word address and data bytes. It answers by pulling SDA low through an active-low output enable. The enable goes low for acknowledges and for zero bits of read data, and is released at every other time. Received write data goes into a page staging unit. A stop hands the staged page over with a commit pulse. The staging unit then runs a self-timed programming cycle and reports busy until it finishes.

The controller is one state machine with these states: IDLE, RX_DEV (device select bits), RX_WORD (word address bits), RX_DATA (write data bits), ACK_WAIT (byte complete, waiting for the 8th SCL fall), ACK_DRIVE (SDA held low through the 9th clock), TX_DATA (read bits out), TX_MACK (sampling the master's acknowledge) and TX_NEXT (master acknowledged, waiting for the fall to load the next byte). The transitions are as follows:
- A start moves any state to RX_DEV, and a stop moves any state to IDLE.
- RX_DEV goes to ACK_WAIT on a match and to IDLE otherwise. RX_WORD and RX_DATA go to ACK_WAIT after eight bits.
- ACK_WAIT goes to ACK_DRIVE on the next fall. ACK_DRIVE then goes, on the next fall, to RX_WORD, RX_DATA or TX_DATA.
- TX_DATA goes to TX_MACK after eight bits. TX_MACK goes to TX_NEXT on an acknowledge and to IDLE on a not-acknowledge. TX_NEXT goes to TX_DATA.

Top module: `twi_eeprom_slave`

## Requirements
- R1: A start (SDA falling while SCL is high) from any state, reset included, restarts device-select reception with SDA released. A stop (SDA rising while SCL is high) returns to idle with SDA released.
- R2: The device select byte is sent MSB first. Its bits 7:4 must equal 1010, bits 3:1 are ignored and bit 0 selects read (1) or write (0). A match is acknowledged by driving SDA low for the whole 9th SCL clock.
- R3: A select byte whose upper nibble is not 1010 gets no acknowledge, and every later bit is ignored until the next start.
- R4: In write mode the second byte loads the address counter, and every data byte is acknowledged on its 9th clock. A stop after at least one data byte starts programming. A stop right after the word address programs nothing and leaves the slave ready at once.
- R5: During a write the low 4 address bits step by one per data byte and wrap within the 16-byte page, while the upper 4 bits stay fixed. A 17th byte overwrites the first column written.
- R6: While programming is in progress, a device select byte of either direction is not acknowledged. After programming it is acknowledged normally.
- R7: A read-mode select returns the byte at the address counter, MSB first, and leaves the counter at that address plus one.
- R8: A master acknowledge after a read byte makes the slave send the next byte. The counter wraps from 255 to 0 and crosses page boundaries.
- R9: A master not-acknowledge ends the read. SDA stays released, and the following stop leaves the slave idle.
- R10: A write select plus word address followed by a repeated start gives a read from the loaded address. Nothing is programmed, so the next select is acknowledged at once.
- R11: The slave changes its SDA drive only while SCL is low, and it samples incoming bits on the SCL rising edge.
- R12: A read data bit of 1 leaves SDA released and a bit of 0 pulls it low, held through the whole high phase of that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronised serial clock level |
| sda_i | input | 1 | Synchronised serial data level (wired-AND bus value) |
| sda_oe_n | output | 1 | 0 pulls SDA low, 1 releases the line |

## Verification
The bench drives the bus as a bit-level master. A behavioural model of the memory and address counter predicts the enable on every system clock of each SCL high phase. The corner cases it targets are these:
- Polling during programming. A design that acknowledges too early would answer a select with stale data.
- A 17-byte page write. A design that lets the column carry into the row would corrupt the next page.
- A sequential read across 255 to 0 and across a page edge. A design that wraps reads within the page would return the wrong byte.
- A random read and a stop right after the word address. A design that commits on any stop would go busy and withhold the next acknowledge.
- A mismatched select followed by more bytes. A design that keeps decoding would acknowledge stray bytes or move the counter.

// File: rtl/twi_ee_pkg.sv
package twi_ee_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 8;
    localparam logic [3:0] DEV_TYPE = 4'b1010;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RX_DEV,
        ST_RX_WORD,
        ST_RX_DATA,
        ST_ACK_WAIT,
        ST_ACK_DRIVE,
        ST_TX_DATA,
        ST_TX_MACK,
        ST_TX_NEXT
    } ee_state_t;
endpackage

// File: rtl/twi_line_monitor.sv
module twi_line_monitor (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det,
    output logic scl_lvl
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    assign scl_rise  = scl_i & ~scl_q;
    assign scl_fall  = ~scl_i & scl_q;
    assign start_det = scl_i & scl_q & sda_q & ~sda_i;
    assign stop_det  = scl_i & scl_q & ~sda_q & sda_i;
    assign scl_lvl   = scl_q;
endmodule

// File: rtl/twi_ee_array.sv
module twi_ee_array
    import twi_ee_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [BYTE_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [BYTE_W-1:0] rdata_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [BYTE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
        end else if (we_i) begin
            cells[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = cells[raddr_i];
endmodule

// File: rtl/twi_page_prog.sv
module twi_page_prog
    import twi_ee_pkg::*;
#(
    parameter int COL_W       = 4,
    parameter int PROG_CYCLES = 1000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load_i,
    input  logic [COL_W-1:0]         load_col_i,
    input  logic [ADDR_W-COL_W-1:0]  load_row_i,
    input  logic [BYTE_W-1:0]        load_data_i,
    input  logic                     commit_i,
    input  logic                     abort_i,
    output logic                     busy_o,
    output logic                     we_o,
    output logic [ADDR_W-1:0]        waddr_o,
    output logic [BYTE_W-1:0]        wdata_o
);
    localparam int PAGE  = 1 << COL_W;
    localparam int ROW_W = ADDR_W - COL_W;
    localparam int CNT_W = $clog2(PROG_CYCLES + 1);

    logic [CNT_W-1:0]       cnt;
    logic [ROW_W-1:0]       row_q;
    logic [PAGE*BYTE_W-1:0] buf_flat;
    logic [PAGE-1:0]        vld_flat;
    logic [COL_W-1:0]       idx;
    logic                   done;

    assign idx  = cnt[COL_W-1:0];
    assign done = busy_o && (cnt == CNT_W'(PROG_CYCLES - 1));

    for (genvar g = 0; g < PAGE; g++) begin : g_ent
        logic [BYTE_W-1:0] ent_q;
        logic              vld_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_q <= '0;
                vld_q <= 1'b0;
            end else if (done) begin
                vld_q <= 1'b0;
            end else if (!busy_o && abort_i) begin
                vld_q <= 1'b0;
            end else if (!busy_o && load_i && load_col_i == COL_W'(g)) begin
                ent_q <= load_data_i;
                vld_q <= 1'b1;
            end
        end
        assign buf_flat[g*BYTE_W +: BYTE_W] = ent_q;
        assign vld_flat[g] = vld_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_o <= 1'b0;
            cnt    <= '0;
            row_q  <= '0;
        end else begin
            if (!busy_o && load_i) row_q <= load_row_i;
            if (!busy_o && commit_i) begin
                busy_o <= 1'b1;
                cnt    <= '0;
            end else if (done) begin
                busy_o <= 1'b0;
            end else if (busy_o) begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end

    assign we_o    = busy_o && (cnt < CNT_W'(PAGE)) && vld_flat[idx];
    assign waddr_o = {row_q, idx};
    assign wdata_o = buf_flat[idx*BYTE_W +: BYTE_W];

    // R6: the controller never stages data while a program cycle runs
    p_no_load_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !load_i)
        else $error("load during programming");

    // R4: an accepted commit starts the timed cycle
    p_commit_starts_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && !busy_o) |=> busy_o)
        else $error("commit did not start programming");

    // R4: commit is only issued when some byte is staged
    p_commit_has_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        commit_i |-> (|vld_flat))
        else $error("commit with empty page");
endmodule

// File: rtl/twi_eeprom_slave.sv
module twi_eeprom_slave
    import twi_ee_pkg::*;
#(
    parameter int COL_W       = 4,
    parameter int PROG_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe_n
);
    localparam int ROW_W = ADDR_W - COL_W;
    localparam int BC_W  = $clog2(BYTE_W);
    localparam logic [BC_W-1:0] LAST_BIT = BC_W'(BYTE_W - 1);

    ee_state_t          state, state_nx, after_ack;
    logic [BC_W-1:0]    bit_cnt;
    logic [BYTE_W-2:0]  shreg;
    logic [BYTE_W-2:0]  txsh;
    logic [ADDR_W-1:0]  ptr;
    logic               sda_low;
    logic               have_data;
    logic [BYTE_W-1:0]  rx_byte;
    logic               last_bit;
    logic               dev_ok;

    logic scl_rise, scl_fall, start_det, stop_det, scl_lvl;
    logic busy, mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [BYTE_W-1:0] mem_wdata, rdata;
    logic load, commit;

    twi_line_monitor u_mon (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det), .scl_lvl(scl_lvl)
    );

    twi_page_prog #(.COL_W(COL_W), .PROG_CYCLES(PROG_CYCLES)) u_prog (
        .clk(clk), .rst_n(rst_n),
        .load_i(load), .load_col_i(ptr[COL_W-1:0]), .load_row_i(ptr[ADDR_W-1:COL_W]),
        .load_data_i(rx_byte), .commit_i(commit), .abort_i(start_det),
        .busy_o(busy), .we_o(mem_we), .waddr_o(mem_waddr), .wdata_o(mem_wdata)
    );

    twi_ee_array u_mem (
        .clk(clk), .rst_n(rst_n), .we_i(mem_we), .waddr_i(mem_waddr),
        .wdata_i(mem_wdata), .raddr_i(ptr), .rdata_o(rdata)
    );

    assign rx_byte  = {shreg, sda_i};
    assign last_bit = (bit_cnt == LAST_BIT);
    assign dev_ok   = (rx_byte[7:4] == DEV_TYPE) && !busy;
    assign load     = (state == ST_RX_DATA) && scl_rise && last_bit;
    assign commit   = stop_det && have_data;
    assign sda_oe_n = ~sda_low;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        if (start_det) begin
            state_nx = ST_RX_DEV;
        end else if (stop_det) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:      state_nx = ST_IDLE;
                ST_RX_DEV:    if (scl_rise && last_bit) state_nx = dev_ok ? ST_ACK_WAIT : ST_IDLE;
                ST_RX_WORD,
                ST_RX_DATA:   if (scl_rise && last_bit) state_nx = ST_ACK_WAIT;
                ST_ACK_WAIT:  if (scl_fall) state_nx = ST_ACK_DRIVE;
                ST_ACK_DRIVE: if (scl_fall) state_nx = after_ack;
                ST_TX_DATA:   if (scl_fall && last_bit) state_nx = ST_TX_MACK;
                ST_TX_MACK:   if (scl_rise) state_nx = sda_i ? ST_IDLE : ST_TX_NEXT;
                ST_TX_NEXT:   if (scl_fall) state_nx = ST_TX_DATA;
                default:      state_nx = ST_IDLE;
            endcase
        end
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            shreg     <= '0;
            txsh      <= '0;
            ptr       <= '0;
            sda_low   <= 1'b0;
            have_data <= 1'b0;
            after_ack <= ST_IDLE;
        end else if (start_det || stop_det) begin
            sda_low   <= 1'b0;
            bit_cnt   <= '0;
            have_data <= 1'b0;
        end else begin
            unique case (state)
                ST_RX_DEV, ST_RX_WORD, ST_RX_DATA: begin
                    if (scl_rise) begin
                        shreg   <= rx_byte[BYTE_W-2:0];
                        bit_cnt <= bit_cnt + BC_W'(1);
                        if (last_bit) begin
                            if (state == ST_RX_DEV) begin
                                after_ack <= rx_byte[0] ? ST_TX_DATA : ST_RX_WORD;
                            end else if (state == ST_RX_WORD) begin
                                ptr       <= rx_byte;
                                after_ack <= ST_RX_DATA;
                            end else begin
                                have_data        <= 1'b1;
                                ptr[COL_W-1:0]   <= ptr[COL_W-1:0] + COL_W'(1);
                                after_ack        <= ST_RX_DATA;
                            end
                        end
                    end
                end
                ST_ACK_WAIT: begin
                    if (scl_fall) sda_low <= 1'b1;
                end
                ST_ACK_DRIVE: begin
                    if (scl_fall) begin
                        bit_cnt <= '0;
                        if (after_ack == ST_TX_DATA) begin
                            sda_low <= ~rdata[BYTE_W-1];
                            txsh    <= rdata[BYTE_W-2:0];
                            ptr     <= ptr + ADDR_W'(1);
                        end else begin
                            sda_low <= 1'b0;
                        end
                    end
                end
                ST_TX_DATA: begin
                    if (scl_fall) begin
                        if (last_bit) begin
                            sda_low <= 1'b0;
                            bit_cnt <= '0;
                        end else begin
                            sda_low <= ~txsh[BYTE_W-2];
                            txsh    <= {txsh[BYTE_W-3:0], 1'b0};
                            bit_cnt <= bit_cnt + BC_W'(1);
                        end
                    end
                end
                ST_TX_NEXT: begin
                    if (scl_fall) begin
                        sda_low <= ~rdata[BYTE_W-1];
                        txsh    <= rdata[BYTE_W-2:0];
                        ptr     <= ptr + ADDR_W'(1);
                        bit_cnt <= '0;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    // R1: a start always restarts select reception with the line free
    p_start_restarts_r1: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_RX_DEV && !sda_low))
        else $error("start not honoured");

    // R9: a stop always lands in idle with the line free
    p_stop_idles_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == ST_IDLE && !sda_low))
        else $error("stop not honoured");

    // R11: SDA drive moves only while SCL is low
    p_drive_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_low) |-> !scl_lvl)
        else $error("SDA drive changed with SCL high");

    // R3: idle never pulls the line
    p_idle_released_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_low)
        else $error("line driven while idle");
endmodule

// File: tb/twi_eeprom_slave_tb_top.sv
module twi_eeprom_slave_tb_top;
    localparam int H    = 4;
    localparam int PROG = 1000;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n = 1'b0;
    logic scl   = 1'b1;
    logic msda  = 1'b1;
    logic oe_n;
    logic bus;
    assign bus = msda & oe_n;

    twi_eeprom_slave #(.COL_W(4), .PROG_CYCLES(PROG)) dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(bus), .sda_oe_n(oe_n)
    );

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] mem_m [256];
    logic [7:0] ptr_m = 8'h00;
    logic [7:0] wq [$];

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cmp(input logic act, input logic exp, input string req);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: sda_oe_n actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic slot(input logic mdrv, input logic exp_oe, input string req);
        scl = 1'b0; tick(1);
        msda = mdrv; tick(H - 1);
        scl = 1'b1;
        for (int i = 0; i < H; i++) begin
            tick(1);
            cmp(oe_n, exp_oe, req);
        end
    endtask

    task automatic bus_start(input string req);
        scl = 1'b0; tick(1);
        msda = 1'b1; tick(H - 1);
        scl = 1'b1; tick(H);
        msda = 1'b0; tick(H);
        cmp(oe_n, 1'b1, req);
    endtask

    task automatic bus_stop(input string req);
        scl = 1'b0; tick(1);
        msda = 1'b0; tick(H - 1);
        scl = 1'b1; tick(H);
        msda = 1'b1; tick(H);
        cmp(oe_n, 1'b1, req);
    endtask

    task automatic send_byte(input logic [7:0] b, input logic ack, input string req);
        for (int i = 7; i >= 0; i--) slot(b[i], 1'b1, req);
        slot(1'b1, ~ack, req);
    endtask

    task automatic recv_byte(input logic [7:0] exp, input logic mack, input string req);
        for (int i = 7; i >= 0; i--) slot(1'b1, exp[i], req);
        slot(~mack, 1'b1, req);
    endtask

    // write wq starting at address a; model applies page wrap
    task automatic do_write(input logic [7:0] dev, input logic [7:0] a, input string req);
        logic [3:0] col;
        bus_start(req);
        send_byte(dev, 1'b1, req);
        send_byte(a, 1'b1, req);
        foreach (wq[i]) send_byte(wq[i], 1'b1, req);
        bus_stop(req);
        col = a[3:0];
        foreach (wq[i]) begin
            mem_m[{a[7:4], col}] = wq[i];
            col = col + 4'd1;
        end
        ptr_m = {a[7:4], col};
    endtask

    task automatic cur_read(input logic [7:0] dev, input int n, input string req);
        bus_start(req);
        send_byte(dev, 1'b1, req);
        for (int i = 0; i < n; i++) begin
            recv_byte(mem_m[ptr_m], i < n - 1, req);
            ptr_m = ptr_m + 8'd1;
        end
        bus_stop(req);
    endtask

    task automatic rand_read(input logic [7:0] a, input int n, input string req);
        bus_start(req);
        send_byte(8'hA0, 1'b1, req);
        send_byte(a, 1'b1, req);
        ptr_m = a;
        cur_read(8'hA1, n, req);
    endtask

    initial begin
        tick(200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem_m[i] = 8'h00;
        tick(3);
        cmp(oe_n, 1'b1, "R1 reset");
        rst_n = 1'b1;
        tick(3);
        cmp(oe_n, 1'b1, "R1 idle");

        // R4 byte write, then R6 poll while busy
        wq = '{8'hA5};
        do_write(8'hA0, 8'h10, "R4 byte write");
        bus_start("R6");
        send_byte(8'hA1, 1'b0, "R6 busy read select");
        bus_stop("R6");
        bus_start("R6");
        send_byte(8'hA0, 1'b0, "R6 busy write select");
        bus_stop("R6");
        tick(PROG + 100);
        // R7 current address read after programming
        cur_read(8'hA1, 1, "R7 current read");

        // R10 random read of written byte; no commit follows
        rand_read(8'h10, 1, "R10 random read");
        cur_read(8'hA1, 1, "R10 no programming started");

        // R4 stop right after word address commits nothing
        bus_start("R4");
        send_byte(8'hA0, 1'b1, "R4 select");
        send_byte(8'h20, 1'b1, "R4 address only");
        bus_stop("R4");
        ptr_m = 8'h20;
        cur_read(8'hA1, 1, "R4 ready at once");

        // R2 ignored select bits, R5 wrap within page
        wq = '{8'h11, 8'h12, 8'h13, 8'h14};
        do_write(8'hAE, 8'h3E, "R2 R5 page write");
        tick(PROG + 100);
        rand_read(8'h3E, 3, "R5 R8 read across page");
        rand_read(8'h30, 2, "R5 wrapped columns");

        // R5 seventeen bytes overwrite the first column
        wq = {};
        for (int i = 0; i < 17; i++) wq.push_back(8'h60 + 8'(i));
        do_write(8'hA6, 8'h50, "R5 overlong page");
        tick(PROG + 100);
        rand_read(8'h50, 3, "R5 overwrite check");

        // R8 wrap 255 -> 0
        wq = '{8'hC3};
        do_write(8'hA0, 8'hFF, "R8 setup");
        tick(PROG + 100);
        wq = '{8'h3C};
        do_write(8'hA0, 8'h00, "R8 setup");
        tick(PROG + 100);
        rand_read(8'hFE, 4, "R8 R12 wrap read");

        // R3 mismatched select, then stray bytes ignored
        bus_start("R3");
        send_byte(8'h90, 1'b0, "R3 mismatch");
        send_byte(8'h00, 1'b0, "R3 ignored byte");
        send_byte(8'hA1, 1'b0, "R3 ignored select pattern");
        bus_stop("R3");
        cur_read(8'hA1, 2, "R3 R9 counter untouched");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule